// File: doc/BRIEF.md
# Segment and Strobe Output Ports

This block holds the two output ports of a small 4-bit controller. A one-cycle opcode strobe comes with an 8-bit opcode, the accumulator value, the 4-bit index register and the status flag. Four opcodes act on the ports. All others, and every cycle without the strobe, leave both ports as they are.

The 8-bit display port is loaded from the accumulator in one of two ways, and the status flag picks the way at the moment of the transfer. With status clear, the nibble passes through unchanged. With status set, the nibble is converted to the segment pattern of its hexadecimal digit. A second opcode blanks the display port. The 11-bit strobe port is never written as a word: one opcode sets and another clears the single bit that the index register points at. Index values past the last implemented bit are ignored. Both ports are registered, so an opcode's effect shows on the cycle after its strobe.

Top module: `outport_unit`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first cycle after it is released, disp_o is 0x00 and strobe_o is 0.
- R2: Strobe with opcode 0x0A and status 0 loads disp_o[3:0] with acc_i and drives disp_o[7:4] to 0.
- R3: Strobe with opcode 0x0A and status 1 loads disp_o with the active-high segment pattern of acc_i (bit 0 = a through bit 6 = g, bit 7 = 0). For digits 0..F in order the patterns are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R4: Strobe with opcode 0x0B clears all eight bits of disp_o.
- R5: Strobe with opcode 0x0C and idx_i below 11 sets strobe_o[idx_i] and changes no other bit.
- R6: Strobe with opcode 0x0D and idx_i below 11 clears strobe_o[idx_i] and changes no other bit.
- R7: Opcode 0x0C or 0x0D with idx_i of 11 to 15 leaves strobe_o unchanged.
- R8: Any other opcode, or any cycle with op_stb_i low, leaves both ports unchanged. The R opcodes do not touch disp_o, and the display opcodes do not touch strobe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_stb_i | input | 1 | Opcode valid for this cycle |
| opcode_i | input | 8 | Opcode being executed |
| acc_i | input | 4 | Accumulator value |
| idx_i | input | 4 | Index register, selects the strobe bit |
| status_i | input | 1 | Status flag, selects the display mode |
| disp_o | output | 8 | Display port |
| strobe_o | output | 11 | Strobe port |

## Verification
On every cycle, the assertions check that the ports hold unless a qualifying opcode arrives. They also check that a strobe-port opcode flips at most one bit, that the blank opcode clears the display, and that the pass-through transfer keeps the upper nibble at zero. Only the bench's scenarios can show that each bit lands at the right index, with the correct direction, and that all sixteen segment patterns match the digit table. The bench sweeps every accumulator value under both status values, every index value for both R opcodes, and all remaining opcodes.

// File: rtl/outport_pkg.sv
package outport_pkg;
    localparam int NIB_W  = 4;
    localparam int DISP_W = 8;
    localparam int OPC_W  = 8;

    localparam logic [OPC_W-1:0] OPC_XFER  = 8'h0A;
    localparam logic [OPC_W-1:0] OPC_BLANK = 8'h0B;
    localparam logic [OPC_W-1:0] OPC_RSET  = 8'h0C;
    localparam logic [OPC_W-1:0] OPC_RCLR  = 8'h0D;

    typedef struct packed {
        logic [DISP_W-1:0] disp;
    } disp_state_t;
endpackage

// File: rtl/hexseg_decode.sv
module hexseg_decode
    import outport_pkg::*;
(
    input  logic [NIB_W-1:0]  digit,
    output logic [DISP_W-1:0] pattern
);
    logic [6:0] seg;

    always_comb begin
        unique case (digit)
            4'h0: seg = 7'b0111111;
            4'h1: seg = 7'b0000110;
            4'h2: seg = 7'b1011011;
            4'h3: seg = 7'b1001111;
            4'h4: seg = 7'b1100110;
            4'h5: seg = 7'b1101101;
            4'h6: seg = 7'b1111101;
            4'h7: seg = 7'b0000111;
            4'h8: seg = 7'b1111111;
            4'h9: seg = 7'b1101111;
            4'hA: seg = 7'b1110111;
            4'hB: seg = 7'b1111100;
            4'hC: seg = 7'b0111001;
            4'hD: seg = 7'b1011110;
            4'hE: seg = 7'b1111001;
            default: seg = 7'b1110001;
        endcase
        // decimal point held dark
        pattern = {1'b0, seg};
    end
endmodule

// File: rtl/disp_port.sv
module disp_port
    import outport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_stb_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [NIB_W-1:0]  acc_i,
    input  logic              status_i,
    output logic [DISP_W-1:0] disp_o
);
    disp_state_t st_d, st_q;
    logic [DISP_W-1:0] seg_pat;

    hexseg_decode u_seg (
        .digit   (acc_i),
        .pattern (seg_pat)
    );

    always_comb begin
        st_d = st_q;
        if (op_stb_i) begin
            if (opcode_i == OPC_XFER) begin
                st_d.disp = status_i ? seg_pat
                                     : {{(DISP_W-NIB_W){1'b0}}, acc_i};
            end else if (opcode_i == OPC_BLANK) begin
                st_d.disp = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disp_o = st_q.disp;

    // R8: hold unless a display opcode is strobed
    a_r8_disp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_stb_i && (opcode_i == OPC_XFER || opcode_i == OPC_BLANK))
        |=> $stable(disp_o));

    // R4
    a_r4_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb_i && opcode_i == OPC_BLANK) |=> (disp_o == '0));

    // R2
    a_r2_pass_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb_i && opcode_i == OPC_XFER && !status_i)
        |=> (disp_o[DISP_W-1:NIB_W] == '0 && disp_o[NIB_W-1:0] == $past(acc_i)));

    // R3: decimal point never lit
    a_r3_dp_dark: assert property (@(posedge clk) disable iff (!rst_n)
        disp_o[DISP_W-1] == 1'b0);
endmodule

// File: rtl/strobe_port.sv
module strobe_port
    import outport_pkg::*;
#(
    parameter int R_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_stb_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [NIB_W-1:0]  idx_i,
    output logic [R_BITS-1:0] strobe_o
);
    localparam int IDX_LIMIT = R_BITS;

    typedef struct packed {
        logic [R_BITS-1:0] bits;
    } strobe_state_t;

    strobe_state_t st_d, st_q;
    logic              in_range;
    logic [R_BITS-1:0] sel_mask;

    always_comb begin
        in_range = (32'(idx_i) < IDX_LIMIT);
        sel_mask = '0;
        for (int i = 0; i < R_BITS; i++) begin
            sel_mask[i] = (32'(idx_i) == i);
        end
        st_d = st_q;
        if (op_stb_i && in_range) begin
            if (opcode_i == OPC_RSET)      st_d.bits = st_q.bits | sel_mask;
            else if (opcode_i == OPC_RCLR) st_d.bits = st_q.bits & ~sel_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = st_q.bits;

    // R7 / R8: no change unless an in-range strobe opcode arrives
    a_r7_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_stb_i && (opcode_i == OPC_RSET || opcode_i == OPC_RCLR)
          && 32'(idx_i) < IDX_LIMIT)
        |=> $stable(strobe_o));

    // R5 / R6: at most one bit moves per opcode
    a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(strobe_o ^ $past(strobe_o)) <= 1));

    // R5: set never lowers a bit
    a_r5_set_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb_i && opcode_i == OPC_RSET)
        |=> ((strobe_o & $past(strobe_o)) == $past(strobe_o)));

    // R6: clear never raises a bit
    a_r6_clr_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb_i && opcode_i == OPC_RCLR)
        |=> ((strobe_o | $past(strobe_o)) == $past(strobe_o)));
endmodule

// File: rtl/outport_unit.sv
module outport_unit
    import outport_pkg::*;
#(
    parameter int R_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_stb_i,
    input  logic [7:0]        opcode_i,
    input  logic [3:0]        acc_i,
    input  logic [3:0]        idx_i,
    input  logic              status_i,
    output logic [7:0]        disp_o,
    output logic [R_BITS-1:0] strobe_o
);
    disp_port u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_stb_i (op_stb_i),
        .opcode_i (opcode_i),
        .acc_i    (acc_i),
        .status_i (status_i),
        .disp_o   (disp_o)
    );

    strobe_port #(.R_BITS(R_BITS)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_stb_i (op_stb_i),
        .opcode_i (opcode_i),
        .idx_i    (idx_i),
        .strobe_o (strobe_o)
    );

    // R1: first cycle after reset both ports are zero
    a_r1_reset_zero: assert property (@(posedge clk)
        $rose(rst_n) |-> (disp_o == '0 && strobe_o == '0));
endmodule

// File: tb/outport_unit_tb_top.sv
module outport_unit_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  RB = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_stb_i = 1'b0;
    logic [7:0]    opcode_i = '0;
    logic [3:0]    acc_i = '0;
    logic [3:0]    idx_i = '0;
    logic          status_i = 1'b0;
    logic [7:0]    disp_o;
    logic [RB-1:0] strobe_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]    exp_d = '0;
    logic [RB-1:0] exp_r = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    outport_unit #(.R_BITS(RB)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_stb_i(op_stb_i), .opcode_i(opcode_i),
        .acc_i(acc_i), .idx_i(idx_i), .status_i(status_i),
        .disp_o(disp_o), .strobe_o(strobe_o)
    );

    function automatic logic [7:0] seg_of(input logic [3:0] v);
        logic [7:0] t [16] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h07,
                               8'h7F, 8'h6F, 8'h77, 8'h7C, 8'h39, 8'h5E, 8'h79, 8'h71};
        return t[v];
    endfunction

    task automatic check(input string req);
        n_chk++;
        if (disp_o !== exp_d || strobe_o !== exp_r) begin
            n_bad++;
            $display("FAIL %s: disp=%h strobe=%h expected disp=%h strobe=%h",
                     req, disp_o, strobe_o, exp_d, exp_r);
        end
    endtask

    task automatic apply(input logic stb, input logic [7:0] op, input logic [3:0] a,
                         input logic [3:0] y, input logic s, input string req);
        @(negedge clk);
        op_stb_i = stb; opcode_i = op; acc_i = a; idx_i = y; status_i = s;
        @(posedge clk);
        @(negedge clk);
        op_stb_i = 1'b0;
        if (stb) begin
            case (op)
                8'h0A: exp_d = s ? seg_of(a) : {4'h0, a};
                8'h0B: exp_d = 8'h00;
                8'h0C: if (y < RB) exp_r[y] = 1'b1;
                8'h0D: if (y < RB) exp_r[y] = 1'b0;
                default: ;
            endcase
        end
        check(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 after release");

        // R2 and R3 full sweep, interleaved with R4 blanking
        for (int a = 0; a < 16; a++) begin
            apply(1'b1, 8'h0A, 4'(a), 4'(a), 1'b0, "R2 pass-through");
            apply(1'b1, 8'h0A, 4'(a), 4'(a), 1'b1, "R3 segment pattern");
            apply(1'b1, 8'h0B, 4'(a), 4'(a), 1'b1, "R4 blank");
        end

        // R5, R7: set every index, scattered order
        apply(1'b1, 8'h0A, 4'h9, 4'h0, 1'b1, "R3 preload");
        for (int y = 0; y < 16; y++)
            apply(1'b1, 8'h0C, 4'h3, 4'((y * 7) % 16), 1'b0,
                  ((y * 7) % 16) < RB ? "R5 set bit" : "R7 set out of range");
        // R6, R7: clear every index
        for (int y = 15; y >= 0; y--)
            apply(1'b1, 8'h0D, 4'h3, 4'(y), 1'b1,
                  y < RB ? "R6 clear bit" : "R7 clear out of range");
        // R7 with a non-zero pattern present
        apply(1'b1, 8'h0C, 4'h0, 4'd10, 1'b0, "R5 top bit");
        apply(1'b1, 8'h0C, 4'h0, 4'd0, 1'b0, "R5 bottom bit");
        for (int y = RB; y < 16; y++)
            apply(1'b1, 8'h0D, 4'h0, 4'(y), 1'b0, "R7 clear ignored");

        // R8: every other opcode, strobe high
        apply(1'b1, 8'h0A, 4'h6, 4'h0, 1'b0, "R2 preload");
        for (int op = 0; op < 256; op++) begin
            if (op >= 8'h0A && op <= 8'h0D) continue;
            apply(1'b1, 8'(op), 4'(op), 4'(op), op[0], "R8 other opcode");
        end
        // R8: strobe low with qualifying opcodes
        for (int op = 8'h0A; op <= 8'h0D; op++)
            apply(1'b0, 8'(op), 4'hF, 4'h5, 1'b1, "R8 strobe low");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule